// File: doc/BRIEF.md
# Polynomial Sequence Self-Test Checker

This block checks whether a buffer of captured 64-bit words contains the deterministic sequence that a random number generator emits while it runs in its health-check mode. The buffer sits inside the block and is filled through a simple write port. A start pulse launches a run. The run begins with a seed as the expected value. It walks the buffer one word per clock and counts the words equal to the expected value. It then advances the expected value by one polynomial step and walks the buffer again.

The running count of matches is kept across every pass. The run ends with a pass as soon as that count reaches the goal. It ends with a fail once the allowed number of passes is used up without reaching the goal. A one-cycle done pulse reports the outcome, together with a pass flag and the final match count.

The seed, the feedback polynomial, the buffer depth, the goal and the pass limit are all parameters.

Top module: `lfsr_seq_checker`

## Requirements
- R1: While reset is asserted and after it is released, busy, done and pass are 0 and match_total is 0.
- R2: A start pulse while the block is idle launches a run in which the first expected value is SEED. match_total restarts from 0 on every run.
- R3: Buffer word 0 is never compared. A SEED match placed only at address 0 does not count.
- R4: Between passes, the expected value is shifted left by one bit. When the bit shifted out of the top was 1, the shifted value is XORed with POLY. Pass k (counted from 0) compares against the value reached after k such steps.
- R5: Matches add to a running total that is not cleared between passes. Two matching words within one pass both count.
- R6: The run passes at the end of the first pass whose running total is at least GOAL. No further pass is made after that.
- R7: If LIMIT passes complete without the total reaching GOAL, the run ends with pass=0. A match against the value after LIMIT steps is never seen.
- R8: Each pass takes DEPTH-1 cycles, one compared word per cycle. busy stays high for the whole run. done is a single-cycle pulse in the cycle after the last compare, and busy is low in that same cycle.
- R9: A start pulse while busy is high has no effect on the run in progress, its length or its result.
- R10: A write with wr_en high stores wr_data at buffer address wr_addr. A later run sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | $clog2(DEPTH) | Buffer write address |
| wr_data | input | W | Buffer write data |
| start | input | 1 | Launch a run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run, valid with done and held afterwards |
| match_total | output | $clog2(GOAL+DEPTH) | Running match count, final value when done |

## Verification
A wrong expected value or a wrong step rule does not show up as a bad data word. It shows up as a missed match, which changes the number of passes. The run length from start to done therefore gives away the fault within one pass of the first wrong step. A skipped or double-counted address, or a count cleared between passes, moves match_total and the pass flag by the end of the same run. A wrong loop bound moves the done pulse by a whole multiple of DEPTH-1 cycles. For these reasons the bench checks the exact cycle of done on every run, not only the result.

// File: rtl/lfsr_seq_checker.sv
module lfsr_seq_checker #(
  parameter int             W     = 64,
  parameter int             DEPTH = 8,
  parameter int             GOAL  = 1,
  parameter int             LIMIT = 64,
  parameter logic [W-1:0]   SEED  = 64'h5A5A_0F0F_3C3C_9696,
  parameter logic [W-1:0]   POLY  = 64'h231D_CEE9_1262_B8A3,
  localparam int            AW    = $clog2(DEPTH),
  localparam int            IW    = $clog2(LIMIT + 1),
  localparam int            CW    = $clog2(GOAL + DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [CW-1:0] match_total
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] idx;
  logic [IW-1:0] iter;
  logic [W-1:0]  expv;

  wire           hit      = (mem[idx] == expv);
  wire  [CW-1:0] sum      = match_total + CW'(hit);
  wire           last     = (idx == AW'(DEPTH - 1));
  wire           goal_met = (sum >= CW'(GOAL));
  wire           no_more  = (iter == IW'(LIMIT - 1));
  wire  [W-1:0]  next_exp = {expv[W-2:0], 1'b0} ^ (expv[W-1] ? POLY : '0);

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      match_total <= '0;
      idx         <= '0;
      iter        <= '0;
      expv        <= SEED;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy        <= 1'b1;
          pass        <= 1'b0;
          match_total <= '0;
          idx         <= AW'(1);
          iter        <= '0;
          expv        <= SEED;
        end
      end else begin
        match_total <= sum;
        if (!last) begin
          idx <= idx + AW'(1);
        end else if (goal_met || no_more) begin
          busy <= 1'b0;
          done <= 1'b1;
          pass <= goal_met;
        end else begin
          idx  <= AW'(1);
          iter <= iter + IW'(1);
          expv <= next_exp;
        end
      end
    end
  end

endmodule

// File: rtl/lfsr_seq_checker_sva.sv
module lfsr_seq_checker_sva #(
  parameter int  W     = 64,
  parameter int  DEPTH = 8,
  parameter int  GOAL  = 1,
  parameter int  LIMIT = 64,
  localparam int CW    = $clog2(GOAL + DEPTH),
  localparam int KW    = $clog2(LIMIT * (DEPTH - 1) + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic [CW-1:0] match_total
);

  logic [KW-1:0] run_cyc;
  always_ff @(posedge clk)
    if (!rst_n || !busy) run_cyc <= '0;
    else                 run_cyc <= run_cyc + KW'(1);

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) !rst_n |=> !busy && !done && match_total == '0); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> busy && match_total == '0); // R2
  AST_TOTAL_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> match_total >= $past(match_total)); // R5
  AST_PASS_MEANS_GOAL: assert property (@(posedge clk) disable iff (!rst_n) done |-> pass == (match_total >= CW'(GOAL))); // R6
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) run_cyc <= KW'(LIMIT * (DEPTH - 1))); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy)); // R8
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8

endmodule

bind lfsr_seq_checker lfsr_seq_checker_sva #(
  .W(W), .DEPTH(DEPTH), .GOAL(GOAL), .LIMIT(LIMIT)
) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .pass(pass), .match_total(match_total)
);

// File: tb/test_lfsr_seq_checker.sv
module test_lfsr_seq_checker;
  localparam logic [63:0] T_SEED = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] T_POLY = 64'h231D_CEE9_1262_B8A3;
  localparam int NV = 9;
  // byte i of CODE = LFSR step stored at word i, 8'hFF = filler word
  localparam logic [63:0] CODE [NV] = '{
    64'hFFFF_FFFF_FFFF_00FF, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_0AFF_FFFF_FFFF,
    64'hFFFF_FFFF_3FFF_FFFF, 64'hFFFF_FFFF_FF40_FFFF, 64'hFFFF_FFFF_FF03_03FF,
    64'hFFFF_FFFF_FF01_00FF, 64'hFFFF_FF02_FF02_00FF, 64'hFFFF_FFFF_FF03_00FF};
  localparam logic       SEL   [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam logic       EPASS [NV] = '{1, 0, 1, 1, 0, 1, 1, 1, 0};
  localparam int         ETOT  [NV] = '{1, 0, 1, 1, 0, 2, 1, 3, 2};
  localparam int         EITER [NV] = '{1, 64, 11, 64, 64, 4, 1, 3, 4};
  localparam string      REQ   [NV] = '{"R2", "R3 R7", "R4", "R4", "R7", "R5", "R6", "R5", "R7"};

  logic clk = 0, rst_n = 0, wr_en = 0, start1 = 0, start2 = 0;
  logic [2:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic busy1, done1, pass1, busy2, done2, pass2;
  logic [3:0] tot1;
  logic [3:0] tot2;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  lfsr_seq_checker #(.SEED(T_SEED), .POLY(T_POLY)) i_lfsr_seq_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start1), .busy(busy1), .done(done1), .pass(pass1), .match_total(tot1));

  lfsr_seq_checker #(.SEED(T_SEED), .POLY(T_POLY), .GOAL(3), .LIMIT(4)) i_lfsr_seq_checker_acc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start2), .busy(busy2), .done(done2), .pass(pass2), .match_total(tot2));

  function automatic logic [63:0] lfsr_at(input int k);
    logic [63:0] v = T_SEED;
    for (int s = 0; s < k; s++) v = v[63] ? ({v[62:0], 1'b0} ^ T_POLY) : {v[62:0], 1'b0};
    return v;
  endfunction

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_word(input int a, input logic [63:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load(input int v);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b = CODE[v][8*i +: 8];
      write_word(i, (b == 8'hFF) ? (64'hF00D_0000_0000_0000 | 64'(v << 8) | 64'(i)) : lfsr_at(int'(b)));
    end
  endtask

  // returns negedges from the start negedge to the first one that sees done
  task automatic run(input logic sel, input int poke, output int cyc, output logic p, output int t);
    @(negedge clk);
    if (sel) start2 = 1; else start1 = 1;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      start1 = (!sel && cyc == poke);
      start2 = (sel && cyc == poke);
      if ((sel ? done2 : done1) || cyc > 600) break;
    end
    start1 = 0; start2 = 0;
    p = sel ? pass2 : pass1;
    t = sel ? int'(tot2) : int'(tot1);
    @(negedge clk);
    chk(!(sel ? done2 : done1), "R8", "done not a single pulse", 1, 0);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, t;
    logic p;
    repeat (3) @(negedge clk);
    chk(!busy1 && !done1 && !pass1 && tot1 == 0, "R1", "state during reset", int'(tot1), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy1 && !done1 && !busy2 && tot2 == 0, "R1", "state after reset", int'(busy1), 0);

    for (int v = 0; v < NV; v++) begin
      load(v);
      run(SEL[v], -1, cyc, p, t);
      chk(p == EPASS[v], REQ[v], $sformatf("vector %0d pass", v), int'(p), int'(EPASS[v]));
      chk(t == ETOT[v], REQ[v], $sformatf("vector %0d match_total", v), t, ETOT[v]);
      chk(cyc == EITER[v] * 7 + 1, "R8", $sformatf("vector %0d cycles to done", v), cyc, EITER[v] * 7 + 1);
    end

    // R9: start pulse in the middle of a run
    load(2);
    run(0, 3, cyc, p, t);
    chk(cyc == 78 && p == 1 && t == 1, "R9", "start while busy changed run", cyc, 78);
    chk(!busy1, "R9", "busy after run with extra start", int'(busy1), 0);

    // R10: overwrite the matching word, then rerun
    load(0);
    write_word(1, 64'hFFFF_0000_1111_2222);
    run(0, -1, cyc, p, t);
    chk(p == 0 && t == 0, "R10", "rewritten word still matched", t, 0);
    chk(cyc == 64 * 7 + 1, "R10", "cycles after rewrite", cyc, 449);
    write_word(7, lfsr_at(5));
    run(0, -1, cyc, p, t);
    chk(p == 1 && cyc == 6 * 7 + 1, "R10", "new word at last address", cyc, 43);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule